// File: doc/BRIEF.md
# Two-Processor Channel Flag Mailbox

This block lets two processors signal each other over a set of numbered channels. Each processor owns one occupied flag per channel. A processor raises one of its own flags to tell its peer that a message is waiting. The peer sees the flag, takes the message, and then lowers the flag through its own command register. The message payload itself lives elsewhere.

Each processor has a separate request port that reaches the whole register map. Each processor has an address window: window 0 starts at 0x000 and window 1 starts at 0x010. A window holds two registers:
- a write-only command register at offset 0x008;
- a read-only status register at offset 0x00C.

A shared configuration register at 0x3F0 reports the channel count. Each processor also gets two interrupt outputs:
- a level receive interrupt, high while any flag of its peer is up;
- a one-cycle transmit-free pulse, raised when the peer lowers one of its flags.

Each request port has a valid/ready handshake. `req_ready` is always high, so the block never applies back-pressure, and a request is accepted in every cycle where `req_valid` is high. A read is answered exactly one cycle later on `rsp_valid`/`rsp_rdata`. The response has no ready signal, and the requester must take it in that cycle.

Top module: `mbx_chan_flags`

## Requirements
- R1: After reset, all flags are 0. Every interrupt output, every `rsp_valid` and every `rsp_rdata` is 0.
- R2: A write to the command register of window p (address p*0x010+0x008) with bit 16+n set, where n < NCH, raises flag n of processor p from the next cycle. After that, bit n of window p's status register (p*0x010+0x00C) reads 1.
- R3: A write to the command register of window p with bit n set, where n < NCH, lowers flag n of the other processor from the next cycle.
- R4: Command bits written as 0 leave their flags unchanged. Flags only change through command writes.
- R5: Set and clear bits for channels n >= NCH are ignored. Status bits NCH and above always read 0.
- R6: When a flag is set and cleared in the same cycle, from either port or from both ports, the flag ends up set.
- R7: Reading address 0x3F0 returns NCH in bits 7:0 and 0 in every other bit.
- R8: Reads of the command registers and of unmapped addresses return 0. Writes to the status and configuration registers change nothing.
- R9: `rx_irq[p]` is high in exactly those cycles where at least one flag of the other processor is set.
- R10: `tx_free_irq[p]` is high for one cycle, in the cycle after a write that lowers at least one set flag of processor p without also setting that flag. Lowering a flag that is already 0 gives no pulse.
- R11: `req_ready` is always 1. A read accepted in cycle k gives `rsp_valid` in cycle k+1, with data that shows the flags before any write accepted in cycle k. Both ports work independently and in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, one bit per processor port |
| req_ready | output | 2 | Request ready, constant 1 |
| req_write | input | 2 | 1 = write, 0 = read |
| req_addr | input | 2 x ADDR_W | Byte address per port |
| req_wdata | input | 2 x 32 | Write data per port |
| rsp_valid | output | 2 | Read response valid, one cycle after the read |
| rsp_rdata | output | 2 x 32 | Read response data, 0 when no response |
| rx_irq | output | 2 | Level: the peer has at least one flag set |
| tx_free_irq | output | 2 | Pulse: one of this processor's flags was lowered |

## Verification
Some behaviours are checked by assertions on every cycle:
- the flag update rules per channel: set takes effect, set beats clear, a clear lowers the flag, and a flag with no request holds;
- a transmit-free pulse only follows a real falling flag;
- the receive interrupt only rises after a peer set;
- responses follow reads by one cycle, with zero upper bits.

Other behaviours can only be shown by the bench scenarios:
- that windows map to the right processor and that acknowledges reach the peer;
- out-of-range channels, writes to read-only registers and unmapped reads;
- that a read in the same cycle as a write returns the old state;
- that the two ports together reproduce the reference model on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NPROC      = 2;
  localparam int unsigned SET_LSB    = 16;
  localparam int unsigned WIN_STRIDE = 'h010;
  localparam int unsigned OFF_CMD    = 'h008;
  localparam int unsigned OFF_STAT   = 'h00C;
  localparam int unsigned OFF_CFG    = 'h3F0;
  localparam int unsigned CFG_CNT_W  = 8;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CMD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CFG  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      win;
  } reg_sel_t;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel.kind = REG_NONE;
    sel.win  = 1'b0;
    for (int w = 0; w < int'(NPROC); w++) begin
      if (addr == ADDR_W'(w * int'(WIN_STRIDE) + int'(OFF_CMD))) begin
        sel.kind = REG_CMD;
        sel.win  = 1'(w);
      end
      if (addr == ADDR_W'(w * int'(WIN_STRIDE) + int'(OFF_STAT))) begin
        sel.kind = REG_STAT;
        sel.win  = 1'(w);
      end
    end
    if (addr == ADDR_W'(OFF_CFG)) begin
      sel.kind = REG_CFG;
    end
  end
endmodule

// File: rtl/mbx_cmd_merge.sv
module mbx_cmd_merge
  import mbx_pkg::*;
#(
  parameter int unsigned NCH    = 12,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NPORT  = 2
) (
  input  logic [NPORT-1:0]             req_valid,
  input  logic [NPORT-1:0]             req_write,
  input  logic [NPORT-1:0][ADDR_W-1:0] req_addr,
  input  logic [NPORT-1:0][DATA_W-1:0] req_wdata,
  output logic [NPROC-1:0][NCH-1:0]    set_req,
  output logic [NPROC-1:0][NCH-1:0]    clr_req
);
  reg_sel_t sel [NPORT];
  logic     unused_wdata;

  assign unused_wdata = ^req_wdata;

  for (genvar g = 0; g < NPORT; g++) begin : g_dec
    mbx_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (req_addr[g]),
      .sel  (sel[g])
    );
  end

  // Set bits hit the writer's own flags; clear bits hit the peer's flags.
  always_comb begin
    set_req = '0;
    clr_req = '0;
    for (int i = 0; i < int'(NPORT); i++) begin
      if (req_valid[i] && req_write[i] && sel[i].kind == REG_CMD) begin
        set_req[sel[i].win]  = set_req[sel[i].win]  | req_wdata[i][SET_LSB +: NCH];
        clr_req[~sel[i].win] = clr_req[~sel[i].win] | req_wdata[i][NCH-1:0];
      end
    end
  end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
  parameter int unsigned NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_req,
  input  logic [NCH-1:0] clr_req,
  output logic [NCH-1:0] flags,
  output logic           txf_pulse
);
  logic [NCH-1:0] freed;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[c] <= 1'b0;
      else if (set_req[c]) flags[c] <= 1'b1;
      else if (clr_req[c]) flags[c] <= 1'b0;
    end

    assign freed[c] = flags[c] & clr_req[c] & ~set_req[c];

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_req[c] |=> flags[c]);                                    // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[c] && !set_req[c]) |=> !flags[c]);                  // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req[c] && !set_req[c]) |=> $stable(flags[c]));         // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n) txf_pulse <= 1'b0;
    else        txf_pulse <= |freed;
  end

  AST_TXF_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pulse |-> (($past(flags) & ~flags) != '0));                // R10
endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port
  import mbx_pkg::*;
#(
  parameter int unsigned NCH    = 12,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [NPROC-1:0][NCH-1:0]  flags,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata
);
  localparam int unsigned PAD_W = DATA_W - NCH;

  reg_sel_t          sel;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_go;

  mbx_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  always_comb begin
    unique case (sel.kind)
      REG_STAT: rd_mux = {{PAD_W{1'b0}}, flags[sel.win]};
      REG_CFG:  rd_mux = DATA_W'(CFG_CNT_W'(NCH));
      default:  rd_mux = '0;
    endcase
  end

  assign rd_go = req_valid & ~req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      rsp_rdata <= rd_go ? rd_mux : '0;
    end
  end

  AST_RSP_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));                 // R11
  AST_RSP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[DATA_W-1:SET_LSB] == '0);                            // R8
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0));                             // R11
endmodule

// File: rtl/mbx_chan_flags.sv
module mbx_chan_flags
  import mbx_pkg::*;
#(
  parameter int unsigned NCH    = 12,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                req_valid,
  output logic [1:0]                req_ready,
  input  logic [1:0]                req_write,
  input  logic [1:0][ADDR_W-1:0]    req_addr,
  input  logic [1:0][DATA_W-1:0]    req_wdata,
  output logic [1:0]                rsp_valid,
  output logic [1:0][DATA_W-1:0]    rsp_rdata,
  output logic [1:0]                rx_irq,
  output logic [1:0]                tx_free_irq
);
  logic [NPROC-1:0][NCH-1:0] set_req;
  logic [NPROC-1:0][NCH-1:0] clr_req;
  logic [NPROC-1:0][NCH-1:0] flags;

  assign req_ready = '1;

  mbx_cmd_merge #(.NCH(NCH), .ADDR_W(ADDR_W), .NPORT(2)) u_cmd (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .set_req   (set_req),
    .clr_req   (clr_req)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    localparam int unsigned PEER = NPROC - 1 - p;

    mbx_flag_bank #(.NCH(NCH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_req   (set_req[p]),
      .clr_req   (clr_req[p]),
      .flags     (flags[p]),
      .txf_pulse (tx_free_irq[p])
    );

    mbx_read_port #(.NCH(NCH), .ADDR_W(ADDR_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[p]),
      .req_write (req_write[p]),
      .req_addr  (req_addr[p]),
      .flags     (flags),
      .rsp_valid (rsp_valid[p]),
      .rsp_rdata (rsp_rdata[p])
    );

    assign rx_irq[p] = |flags[PEER];

    AST_RX_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq[p]) |-> $past(set_req[PEER] != '0));            // R9
  end
endmodule

// File: tb/mbx_chan_flags_tb.sv
`timescale 1ns/1ps
module mbx_chan_flags_tb;
  localparam int NCH  = 12;
  localparam int AW   = 12;
  localparam int MASK = (1 << NCH) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] v = '0, w = '0;
  logic [1:0][AW-1:0] a = '0;
  logic [1:0][31:0] d = '0;
  logic [1:0] rdy, rv, rx, txf;
  logic [1:0][31:0] rd;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur = "R1";

  int unsigned mf [2];
  bit exp_txf [2];
  bit exp_rv [2];
  int unsigned exp_rd [2];

  always #10 clk = ~clk;

  mbx_chan_flags #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_ready(rdy), .req_write(w),
    .req_addr(a), .req_wdata(d), .rsp_valid(rv), .rsp_rdata(rd),
    .rx_irq(rx), .tx_free_irq(txf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned rd_model(input logic [AW-1:0] adr, input int unsigned f0, input int unsigned f1);
    if (adr == 12'h00C) return f0;
    if (adr == 12'h01C) return f1;
    if (adr == 12'h3F0) return NCH;
    return 0;
  endfunction

  task automatic model_update();
    int unsigned s [2];
    int unsigned c [2];
    int unsigned old [2];
    old = mf;
    s[0] = 0; s[1] = 0; c[0] = 0; c[1] = 0;
    for (int i = 0; i < 2; i++) begin
      if (v[i] && w[i]) begin
        for (int p = 0; p < 2; p++) begin
          if (a[i] == AW'(p * 16 + 8)) begin
            s[p]     |= (d[i] >> 16) & MASK;
            c[1 - p] |= d[i] & MASK;
          end
        end
      end
      exp_rv[i] = v[i] && !w[i];
      exp_rd[i] = exp_rv[i] ? rd_model(a[i], old[0], old[1]) : 0;
    end
    for (int p = 0; p < 2; p++) begin
      exp_txf[p] = (old[p] & c[p] & ~s[p]) != 0;
      mf[p] = (old[p] & ~c[p]) | s[p];
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      chk(rdy[p] == 1'b1, {cur, "/R11 ready"}, rdy[p], 1);
      chk(rx[p] == (mf[1 - p] != 0), {cur, "/R9 rx_irq"}, rx[p], mf[1 - p] != 0);
      chk(txf[p] == exp_txf[p], {cur, "/R10 tx_free_irq"}, txf[p], exp_txf[p]);
      chk(rv[p] == exp_rv[p], {cur, "/R11 rsp_valid"}, rv[p], exp_rv[p]);
      chk(rd[p] == exp_rd[p], {cur, " rsp_rdata"}, rd[p], exp_rd[p]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    v = '0; w = '0; a = '0; d = '0;
  endtask

  task automatic wr(input int port, input int adr, input int unsigned data);
    v[port] = 1'b1; w[port] = 1'b1; a[port] = AW'(adr); d[port] = data;
  endtask

  task automatic rdq(input int port, input int adr);
    v[port] = 1'b1; w[port] = 1'b0; a[port] = AW'(adr); d[port] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mf[0] = 0; mf[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rx == 2'b00 && txf == 2'b00 && rv == 2'b00, "R1 irq/rsp", {rx, txf, rv}, 0);
    chk(rd == '0, "R1 rdata", rd[0] | rd[1], 0);
    rst_n = 1'b1;
    cur = "R1"; rdq(0, 'h00C); rdq(1, 'h01C); tick(); tick();

    // R2: set own flags, read via own and peer window
    cur = "R2"; wr(0, 'h008, 32'h0008_0000); tick();
    rdq(0, 'h00C); rdq(1, 'h00C); tick(); tick();
    wr(1, 'h018, 32'h0801_0000); tick();
    rdq(1, 'h01C); tick(); tick();

    // R3 + R10: peer acknowledges
    cur = "R3"; wr(1, 'h018, 32'h0000_0008); tick(); tick();
    rdq(0, 'h00C); tick(); tick();
    cur = "R10"; wr(0, 'h008, 32'h0000_0001); tick(); tick(); // ack an already-clear? bit0 of flag1 is set
    wr(0, 'h008, 32'h0000_0001); tick(); tick();             // now clear: no pulse

    // R4: zero bits do nothing
    cur = "R4"; wr(0, 'h008, 32'h0030_0000); tick();
    wr(0, 'h008, 32'h0000_0000); tick();
    wr(1, 'h018, 32'h0000_0000); tick();
    rdq(0, 'h00C); tick(); tick();

    // R5: out-of-range channels
    cur = "R5"; wr(0, 'h008, 32'hF000_0000); wr(1, 'h018, 32'h0000_F000); tick();
    rdq(0, 'h00C); rdq(1, 'h01C); tick(); tick();

    // R6: set and clear of the same flag in one cycle
    cur = "R6"; wr(0, 'h008, 32'h0010_0000); wr(1, 'h018, 32'h0000_0010); tick();
    rdq(0, 'h00C); tick(); tick();
    wr(1, 'h008, 32'h0020_0000); wr(0, 'h018, 32'h0000_0020); tick();
    rdq(1, 'h00C); tick(); tick();

    // R7: configuration
    cur = "R7"; rdq(0, 'h3F0); rdq(1, 'h3F0); tick(); tick();

    // R8: write-only, unmapped and read-only registers
    cur = "R8"; rdq(0, 'h008); rdq(1, 'h000); tick(); tick();
    rdq(0, 'h3FC); rdq(1, 'h014); tick(); tick();
    wr(0, 'h00C, 32'hFFFF_FFFF); wr(1, 'h3F0, 32'hFFFF_FFFF); tick();
    rdq(0, 'h00C); rdq(1, 'h3F0); tick(); tick();
    wr(0, 'h004, 32'hFFFF_FFFF); tick();
    rdq(1, 'h01C); tick(); tick();

    // R11: read in the same cycle as a write sees old state
    cur = "R11"; rdq(0, 'h00C); wr(1, 'h018, 32'h0000_0FFF); tick();
    rdq(0, 'h00C); rdq(1, 'h01C); tick(); tick();

    // R9: mixed traffic on both ports
    cur = "R9";
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < 2; i++) begin
        int unsigned r;
        r = $urandom;
        if (r[0]) begin
          case (r[3:1])
            3'd0, 3'd1: wr(i, 'h008, $urandom & 32'h0FFF_0FFF);
            3'd2, 3'd3: wr(i, 'h018, $urandom & 32'h0FFF_0FFF);
            3'd4: rdq(i, 'h00C);
            3'd5: rdq(i, 'h01C);
            3'd6: rdq(i, 'h3F0);
            default: wr(i, 'h00C, $urandom);
          endcase
        end
      end
      tick();
    end
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule